// File: doc/BRIEF.md
# Set/Clear GPIO Port with Implicit Direction

This block is a 32-pin general-purpose I/O port on a simple word-addressed register bus. Software never writes the output latch as a whole. It writes a bit mask to a set register or a clear register. Each one-bit in the mask forces that pin's output latch to 1 or to 0, and the same write also makes that pin an output. A third write-only register takes masked pins back to high impedance, so they become inputs again. There is no direction register.

The pad levels reach software through a read-only pin-state register. The pin-state register returns the synchronised level on every pad, whatever the pin's direction. After reset this path reads as zero. It stays dead until software writes the input-enable register once; the data written there is ignored, and only the write event matters.

Pad inputs pass through a two-flop synchroniser before they reach the bus. Register writes take effect on the clock edge that accepts them. Reads are combinational on the same cycle.

Top module: `sc_gpio_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all zero), every output latch is 0 (`pad_out` all zero), and a read of the pin-state register returns 0.
- R2: A write to offset 0x00 (output-set) sets the output latch of every pin whose mask bit is 1, from the edge that accepts the write; pins whose mask bit is 0 keep their latch value.
- R3: A write to offset 0x04 (output-clear) clears the output latch of every pin whose mask bit is 1; pins whose mask bit is 0 keep their latch value.
- R4: A write to offset 0x00 or 0x04 also makes every masked pin an output (`pad_oe` bit 1); the direction of unmasked pins is unchanged.
- R5: A write to offset 0x08 (tristate-clear) makes every masked pin an input (`pad_oe` bit 0) and leaves every output latch unchanged, so `pad_out` holds its value.
- R6: Once input is enabled, a read of offset 0x0C (pin-state) returns, in bit n, the level `pad_in[n]` had two clock edges earlier, for output and input pins alike. A pad change becomes visible after the second rising edge.
- R7: Until the first write to offset 0x10 (input-enable) after reset, pin-state reads return 0. Any write there, including data 0, enables the input path from the next cycle, and the path stays enabled until reset.
- R8: Reads of offsets 0x00, 0x04, 0x08 and 0x10 return 0. Any address that is not word-aligned, or whose word index is above 4, reads 0 and is ignored on write. Writes to offset 0x0C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data (pin mask), bit n for pin n |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pad_in | input | 32 | Level seen on each pad |
| pad_out | output | 32 | Output latch value driven to each pad |
| pad_oe | output | 32 | Pad output enable, 1 = pin is an output |

## Verification
The checker watches every cycle for several rules. After a set or clear write, each masked pin must be an output holding the right level. After a tristate-clear write, the masked pins must be inputs and the output latches must not have moved. Pin-state reads must be zero before the enable write and must equal the pad level from two edges earlier after it. Reads of every non-readable offset must return zero. The bench scenarios cover the rest. They show the reset state and that unmasked pins keep their state across overlapping masks. They show that a write of zero to the enable register still opens the path, that pin-state reads mix driven and external levels, and the exact edge on which a pad change shows up. They also show that misaligned, unmapped and read-only writes leave both latches untouched.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_REGS = 5;

    // Word index of each register; the index is byte address / 4.
    typedef enum logic [2:0] {
        REG_SET  = 3'd0,
        REG_CLR  = 3'd1,
        REG_TCLR = 3'd2,
        REG_PIN  = 3'd3,
        REG_INEN = 3'd4,
        REG_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic tclr;
        logic inen;
    } wr_strobe_t;

    // Map a word index to a register. in_range means the upper index bits
    // are zero and the byte offset is word aligned.
    function automatic reg_sel_e decode_index(input logic [2:0] low_idx,
                                              input logic       in_range);
        reg_sel_e r;
        r = REG_NONE;
        if (in_range) begin
            case (low_idx)
                3'd0:    r = REG_SET;
                3'd1:    r = REG_CLR;
                3'd2:    r = REG_TCLR;
                3'd3:    r = REG_PIN;
                3'd4:    r = REG_INEN;
                default: r = REG_NONE;
            endcase
        end
        return r;
    endfunction

    // Next latch value of one pin for a given strobe set and mask bit.
    function automatic logic next_out(input logic cur, input wr_strobe_t s,
                                      input logic m);
        logic n;
        n = cur;
        if (m && s.set) n = 1'b1;
        if (m && s.clr) n = 1'b0;
        return n;
    endfunction

    function automatic logic next_oe(input logic cur, input wr_strobe_t s,
                                     input logic m);
        logic n;
        n = cur;
        if (m && (s.set || s.clr)) n = 1'b1;
        if (m && s.tclr)           n = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/sc_gpio_regdec.sv
module sc_gpio_regdec
    import sc_gpio_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    output wr_strobe_t    wr_stb,
    output logic          rd_pin
);

    localparam int unsigned IDX_W = AW - 2;

    logic [IDX_W-1:0] idx;
    logic             in_range;
    reg_sel_e         sel;
    logic             wr_ok;

    assign idx = bus_addr[AW-1:2];

    generate
        if (IDX_W > 3) begin : g_wide
            assign in_range = (idx[IDX_W-1:3] == '0) && (bus_addr[1:0] == 2'b00);
        end else begin : g_narrow
            assign in_range = (bus_addr[1:0] == 2'b00);
        end
    endgenerate

    always_comb begin
        sel = decode_index(idx[2:0], in_range);
    end

    assign wr_ok       = bus_sel && bus_we;
    assign wr_stb.set  = wr_ok && (sel == REG_SET);
    assign wr_stb.clr  = wr_ok && (sel == REG_CLR);
    assign wr_stb.tclr = wr_ok && (sel == REG_TCLR);
    assign wr_stb.inen = wr_ok && (sel == REG_INEN);
    assign rd_pin      = bus_sel && !bus_we && (sel == REG_PIN);

endmodule

// File: rtl/sc_gpio_latch.sv
module sc_gpio_latch
    import sc_gpio_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       wr_stb,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] oe_q
);

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q[i] <= 1'b0;
                    oe_q[i]  <= 1'b0;
                end else begin
                    out_q[i] <= next_out(out_q[i], wr_stb, mask[i]);
                    oe_q[i]  <= next_oe(oe_q[i], wr_stb, mask[i]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sc_gpio_insync.sv
module sc_gpio_insync #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inen_wr,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pin_state
);

    logic [NPINS-1:0] stg [STAGES];
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= pad_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    endgenerate

    // Sticky: set by any write to the enable register, cleared by reset only.
    always_ff @(posedge clk) begin
        if (rst)          en_q <= 1'b0;
        else if (inen_wr) en_q <= 1'b1;
    end

    assign pin_state = en_q ? stg[STAGES-1] : '0;

endmodule

// File: rtl/sc_gpio_port.sv
module sc_gpio_port
    import sc_gpio_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned AW     = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    wr_strobe_t       wr_stb;
    logic             rd_pin;
    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] pin_state;

    assign mask = bus_wdata[NPINS-1:0];

    sc_gpio_regdec #(.AW(AW)) u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wr_stb   (wr_stb),
        .rd_pin   (rd_pin)
    );

    sc_gpio_latch #(.NPINS(NPINS)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .mask   (mask),
        .out_q  (pad_out),
        .oe_q   (pad_oe)
    );

    sc_gpio_insync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .inen_wr   (wr_stb.inen),
        .pad_in    (pad_in),
        .pin_state (pin_state)
    );

    assign bus_rdata = rd_pin ? DATA_W'(pin_state) : '0;

endmodule

// File: rtl/sc_gpio_port_chk.sv
module sc_gpio_port_chk #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned AW     = 8,
    parameter int unsigned STAGES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe
);

    logic             a_set, a_clr, a_tclr, a_inen, a_pin;
    logic [NPINS-1:0] m;
    logic             seen_en;
    logic [1:0]       age;

    assign a_set  = bus_sel && bus_we  && (bus_addr == AW'(8'h00));
    assign a_clr  = bus_sel && bus_we  && (bus_addr == AW'(8'h04));
    assign a_tclr = bus_sel && bus_we  && (bus_addr == AW'(8'h08));
    assign a_inen = bus_sel && bus_we  && (bus_addr == AW'(8'h10));
    assign a_pin  = bus_sel && !bus_we && (bus_addr == AW'(8'h0C));
    assign m      = bus_wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_en <= 1'b0;
            age     <= 2'd0;
        end else begin
            if (a_inen)      seen_en <= 1'b1;
            if (age != 2'd3) age     <= age + 2'd1;
        end
    end

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        a_set |=> ((pad_out & $past(m)) == $past(m)));

    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
        a_clr |=> ((pad_out & $past(m)) == '0));

    p_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (a_set || a_clr) |=> ((pad_oe & $past(m)) == $past(m)));

    p_tclr_dir_r5: assert property (@(posedge clk) disable iff (rst)
        a_tclr |=> ((pad_oe & $past(m)) == '0));

    p_tclr_keep_r5: assert property (@(posedge clk) disable iff (rst)
        a_tclr |=> $stable(pad_out));

    p_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (a_pin && !seen_en) |-> (bus_rdata == '0));

    p_rdzero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && !a_pin) |-> (bus_rdata == '0));

    generate
        if (STAGES == 2) begin : g_lat
            p_latency_r6: assert property (@(posedge clk) disable iff (rst)
                (a_pin && seen_en && age >= 2'd2) |->
                    (bus_rdata[NPINS-1:0] == $past(pad_in, 2)));
        end
    endgenerate

endmodule

bind sc_gpio_port sc_gpio_port_chk #(
    .NPINS(NPINS), .AW(AW), .STAGES(STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/sc_gpio_port_tb.sv
module sc_gpio_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] ext_drv = 32'h0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    // Pad model: a driven pin shows its own output, otherwise the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drv);

    sc_gpio_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 32'h0;
    endtask

    // Called right after a negedge; samples the combinational read data.
    task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        ext_drv = 32'hFFFF_FFFF;
        idle(4);
        chk("R1", "oe after reset", pad_oe, 32'h0);
        chk("R1", "out after reset", pad_out, 32'h0);
        rd(8'h0C, d);
        chk("R1", "pin-state after reset", d, 32'h0);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        ext_drv = 32'hA5A5_5A5A;
        idle(4);
        rd(8'h0C, d);
        chk("R7", "pin-state before enable", d, 32'h0);
        wr(8'h10, 32'h0);
        rd_now(8'h0C, d);
        chk("R7", "pin-state after zero-data enable write", d, 32'hA5A5_5A5A);
        idle(3);
        rd(8'h0C, d);
        chk("R7", "enable stays set", d, 32'hA5A5_5A5A);
    endtask

    task automatic t_set;
        wr(8'h00, 32'h0000_00FF);
        chk("R2", "out after set FF", pad_out, 32'h0000_00FF);
        chk("R4", "oe after set FF", pad_oe, 32'h0000_00FF);
        wr(8'h00, 32'hF000_0000);
        chk("R2", "out after set top nibble", pad_out, 32'hF000_00FF);
        chk("R4", "oe after set top nibble", pad_oe, 32'hF000_00FF);
    endtask

    task automatic t_clr;
        wr(8'h04, 32'h0000_000F);
        chk("R3", "out after clear low nibble", pad_out, 32'hF000_00F0);
        chk("R4", "oe after clear of output pins", pad_oe, 32'hF000_00FF);
        wr(8'h04, 32'h00F0_0000);
        chk("R3", "out after clear of input pins", pad_out, 32'hF000_00F0);
        chk("R4", "clear turns pins into outputs", pad_oe, 32'hF0F0_00FF);
    endtask

    task automatic t_tclr;
        wr(8'h08, 32'hF000_0000);
        chk("R5", "oe after tristate-clear", pad_oe, 32'h00F0_00FF);
        chk("R5", "out kept across tristate-clear", pad_out, 32'hF000_00F0);
    endtask

    task automatic t_pin;
        logic [31:0] d, oldv, newv;
        ext_drv = 32'h1234_5678;
        idle(4);
        oldv = (pad_oe & pad_out) | (~pad_oe & 32'h1234_5678);
        rd(8'h0C, d);
        chk("R6", "pin-state mixes driven and external", d, oldv);
        @(negedge clk);
        ext_drv = 32'hEDCB_A987;
        newv = (pad_oe & pad_out) | (~pad_oe & 32'hEDCB_A987);
        rd(8'h0C, d);
        chk("R6", "pin-state one edge after change", d, oldv);
        rd(8'h0C, d);
        chk("R6", "pin-state two edges after change", d, newv);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(8'h00, d); chk("R8", "read of set reg", d, 32'h0);
        rd(8'h04, d); chk("R8", "read of clear reg", d, 32'h0);
        rd(8'h08, d); chk("R8", "read of tristate-clear reg", d, 32'h0);
        rd(8'h10, d); chk("R8", "read of enable reg", d, 32'h0);
        rd(8'h0D, d); chk("R8", "misaligned pin-state read", d, 32'h0);
        rd(8'h14, d); chk("R8", "unmapped read", d, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h45, 32'hFFFF_FFFF);
        chk("R8", "oe after ignored writes", pad_oe, 32'h00F0_00FF);
        chk("R8", "out after ignored writes", pad_out, 32'hF000_00F0);
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gate();
        t_set();
        t_clr();
        t_tclr();
        t_pin();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule